// File: doc/BRIEF.md
# Quarter-Wave Sine Lookup Converter

This block turns a phase word into a signed sine sample suitable for driving a DAC. It is meant to sit behind a phase accumulator, for example inside a chirp or tone generator. The upper bits of the accumulator form a coarse phase and a few further bits form a fractional residue. Only one quarter of a period is held in a ROM. The ROM is filled with computed values when the design is elaborated. The other three quarters are rebuilt in two ways: the ROM address is reflected in odd quarters, and the result is negated in the second half of the cycle. Table entries sit at half-step offsets, so the reflected quarters meet without repeating a sample.

A parameter selects an optional first-order refinement. The residue, taken as a signed offset from the centre of the chosen entry, is multiplied by the local slope of the wave. That slope is the cosine, which comes from the same ROM at the reflected address. The product is added to the table value before the sign is applied. The path is fully pipelined. It accepts a new phase every clock and returns the matching sample a fixed three clocks later, with a valid flag that travels alongside.

Top module: `sine_lut_conv`

## Requirements
- R1: While `rst` is high, `out_valid` is low on the following clock, whatever `in_valid` does. After `rst` falls, `out_valid` stays low until a phase accepted after the reset arrives at the output.
- R2: A phase accepted with `in_valid` high at a rising edge produces `out_valid` high exactly three rising edges later (counting the accepting edge), one sample per clock with no stall. A cycle with `in_valid` low gives `out_valid` low at the same distance.
- R3: With `INTERP`=0, and with P the upper 12 bits of `in_phase` and A = 2^(AMP_W-1)-1 = 32767, `out_sample` is within 1 LSB of A·sin(2π(P+0.5)/4096).
- R4: Coarse phase bit 11 (the MSB of `in_phase`) selects the half-cycle. With `INTERP`=0, the sample for P+2048 is the exact negation of the sample for P, for every P below 2048. With interpolation on, a phase whose MSB is set never gives a positive sample, and a phase whose MSB is clear never gives a negative one.
- R5: Coarse phase bit 10 selects the reflected quarters. With `INTERP`=0, P and 2047-P give identical samples for P in 0..1023, and 2048+P and 4095-P give identical samples for the same range of P.
- R6: With `INTERP`=1, with the full 16-bit phase F = {P, residue}, `out_sample` is within 2 LSB of A·sin(2πF/65536) for every coarse code and residue.
- R7: `out_sample` always lies in [-A, +A]. The most negative two's-complement code never appears.
- R8: With `INTERP`=0, the 4 residue bits (`in_phase[3:0]`) have no effect. The same coarse code gives the same sample whatever the residue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears the valid pipeline |
| in_valid | input | 1 | Phase on `in_phase` is to be converted this cycle |
| in_phase | input | PHASE_W+FRAC_W (16) | Phase: upper PHASE_W bits are the coarse code, lower FRAC_W bits the residue |
| out_valid | output | 1 | `out_sample` holds a converted sample |
| out_sample | output | AMP_W (16) | Two's-complement sine amplitude |

## Verification
The bench sweeps every coarse code through a full-correction instance and a table-only instance side by side. Each output is compared with a real-valued sine. If the reflection used the raw offset instead of its bitwise inverse, the odd quarters would run backwards and the bench would see large errors near quarter boundaries. The quarter edges (codes 1023/1024, 2047/2048, 3071/3072, 4095/0) are driven with residues 0, 8 and 15. If the correction slope were read from the wrong address, or its sign were not flipped in reflected quarters, those points would land several LSB off. After the sweep, the stored table-only samples are tested for exact reflection and negation symmetry, and for independence from the residue. Idle gaps are sprinkled into the stream and inputs are asserted during reset to catch a valid flag that leaks or slips by a cycle.

// File: rtl/sine_lut_pkg.sv
package sine_lut_pkg;

    // pi/2 in unsigned Q2.30 fixed point
    localparam longint HALF_PI_Q30 = 64'd1686629713;

    // Quarter-wave magnitude for entry idx, sampled at the entry centre
    function automatic int quarter_entry(input int idx, input int addr_w, input int peak);
        real ang;
        ang = 1.5707963267948966 * (real'(idx) + 0.5) / real'(1 << addr_w);
        return int'($floor(real'(peak) * $sin(ang) + 0.5));
    endfunction

    // pi/2 rounded to frac_bits fractional bits (frac_bits < 30)
    function automatic longint slope_gain(input int frac_bits);
        longint half_lsb;
        half_lsb = longint'(1) <<< (29 - frac_bits);
        return (HALF_PI_Q30 + half_lsb) >>> (30 - frac_bits);
    endfunction

endpackage

// File: rtl/sine_fold.sv
// Stage 1: split the phase into half-cycle sign, quarter reflection and
// residue; produce the table address and the signed offset from entry centre.
module sine_fold #(
    parameter int PHASE_W = 12,
    parameter int FRAC_W  = 4,
    localparam int FULL_W = PHASE_W + FRAC_W,
    localparam int ADDR_W = PHASE_W - 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [FULL_W-1:0]       in_phase,
    output logic                    f_valid,
    output logic                    f_neg,
    output logic [ADDR_W-1:0]       f_addr,
    output logic signed [FRAC_W:0]  f_delta
);

    localparam logic signed [FRAC_W:0] MID = (FRAC_W + 1)'(1 << (FRAC_W - 1));

    typedef struct packed {
        logic                   valid;
        logic                   neg;
        logic [ADDR_W-1:0]      addr;
        logic signed [FRAC_W:0] delta;
    } fold_t;

    fold_t fold_d, fold_q;

    logic [PHASE_W-1:0]     coarse;
    logic [FRAC_W-1:0]      resid;
    logic                   mirror;
    logic signed [FRAC_W:0] centred;

    always_comb begin
        coarse  = in_phase[FULL_W-1 -: PHASE_W];
        resid   = in_phase[FRAC_W-1:0];
        mirror  = coarse[PHASE_W-2];
        centred = $signed({1'b0, resid}) - MID;

        fold_d.valid = in_valid;
        fold_d.neg   = coarse[PHASE_W-1];
        fold_d.addr  = mirror ? ~coarse[ADDR_W-1:0] : coarse[ADDR_W-1:0];
        // moving forward in phase walks backwards through a reflected table
        fold_d.delta = mirror ? -centred : centred;
    end

    always_ff @(posedge clk) begin
        fold_q <= fold_d;
        if (rst) fold_q.valid <= 1'b0;
    end

    assign f_valid = fold_q.valid;
    assign f_neg   = fold_q.neg;
    assign f_addr  = fold_q.addr;
    assign f_delta = fold_q.delta;

endmodule

// File: rtl/sine_quarter_rom.sv
// Stage 2: quarter-wave table with a sine port and, when interpolation is
// built in, a cosine port at the reflected address.
module sine_quarter_rom #(
    parameter int ADDR_W = 10,
    parameter int MAG_W  = 15,
    parameter int FRAC_W = 4,
    parameter bit INTERP = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    f_valid,
    input  logic                    f_neg,
    input  logic [ADDR_W-1:0]       f_addr,
    input  logic signed [FRAC_W:0]  f_delta,
    output logic                    r_valid,
    output logic                    r_neg,
    output logic [MAG_W-1:0]        r_sin,
    output logic [MAG_W-1:0]        r_cos,
    output logic signed [FRAC_W:0]  r_delta
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PEAK  = (1 << MAG_W) - 1;

    logic [MAG_W-1:0] rom_mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            rom_mem[i] = MAG_W'(sine_lut_pkg::quarter_entry(i, ADDR_W, PEAK));
        end
    end

    typedef struct packed {
        logic                   valid;
        logic                   neg;
        logic [MAG_W-1:0]       sin_v;
        logic [MAG_W-1:0]       cos_v;
        logic signed [FRAC_W:0] delta;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [MAG_W-1:0] slope_rd;

    generate
        if (INTERP) begin : g_slope
            // cosine of entry e equals the sine entry at the reflected index
            always_comb slope_rd = rom_mem[~f_addr];
        end else begin : g_no_slope
            assign slope_rd = '0;
        end
    endgenerate

    always_comb begin
        rd_d.valid = f_valid;
        rd_d.neg   = f_neg;
        rd_d.sin_v = rom_mem[f_addr];
        rd_d.cos_v = slope_rd;
        rd_d.delta = f_delta;
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
        if (rst) rd_q.valid <= 1'b0;
    end

    assign r_valid = rd_q.valid;
    assign r_neg   = rd_q.neg;
    assign r_sin   = rd_q.sin_v;
    assign r_cos   = rd_q.cos_v;
    assign r_delta = rd_q.delta;

endmodule

// File: rtl/sine_amp_recon.sv
// Stage 3: slope correction, clamp to the table range, half-cycle negation.
module sine_amp_recon #(
    parameter int ADDR_W    = 10,
    parameter int MAG_W     = 15,
    parameter int FRAC_W    = 4,
    parameter int GAIN_FRAC = 16,
    parameter bit INTERP    = 1'b1,
    localparam int AMP_W    = MAG_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    r_valid,
    input  logic                    r_neg,
    input  logic [MAG_W-1:0]        r_sin,
    input  logic [MAG_W-1:0]        r_cos,
    input  logic signed [FRAC_W:0]  r_delta,
    output logic                    out_valid,
    output logic signed [AMP_W-1:0] out_sample
);

    localparam int PROD_W = FRAC_W + MAG_W + GAIN_FRAC + 6;
    localparam int SHIFT  = GAIN_FRAC + ADDR_W + FRAC_W;
    localparam int SUM_W  = MAG_W + 2;

    localparam logic signed [PROD_W-1:0] GAIN_V =
        PROD_W'(sine_lut_pkg::slope_gain(GAIN_FRAC));
    localparam logic signed [PROD_W-1:0] HALF_V = PROD_W'(64'sd1 <<< (SHIFT - 1));
    localparam logic signed [SUM_W-1:0]  CEIL_V = SUM_W'((1 << MAG_W) - 1);

    typedef struct packed {
        logic                    valid;
        logic signed [AMP_W-1:0] sample;
    } out_t;

    out_t out_d, out_q;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [SUM_W-1:0]  corr;
    logic signed [SUM_W-1:0]  sum;
    logic [MAG_W-1:0]         mag;

    always_comb begin
        // offset (1/2^FRAC_W entries) * cos * (pi/2) / DEPTH, rounded
        prod   = PROD_W'(r_delta) * PROD_W'($signed({1'b0, r_cos})) * GAIN_V;
        scaled = (prod + HALF_V) >>> SHIFT;
        corr   = INTERP ? SUM_W'(scaled) : '0;
        sum    = SUM_W'($signed({1'b0, r_sin})) + corr;

        if (sum < 0) begin
            mag = '0;
        end else if (sum > CEIL_V) begin
            mag = MAG_W'(CEIL_V);
        end else begin
            mag = sum[MAG_W-1:0];
        end

        out_d.valid  = r_valid;
        out_d.sample = r_neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
        if (rst) out_q.valid <= 1'b0;
    end

    assign out_valid  = out_q.valid;
    assign out_sample = out_q.sample;

    // R7: the asymmetric most-negative code must never be emitted
    p_range_r7: assert property (@(posedge clk) disable iff (rst)
        out_q.valid |-> (out_q.sample != {1'b1, {MAG_W{1'b0}}}));

endmodule

// File: rtl/sine_lut_conv.sv
module sine_lut_conv #(
    parameter int PHASE_W   = 12,
    parameter int FRAC_W    = 4,
    parameter int AMP_W     = 16,
    parameter int GAIN_FRAC = 16,
    parameter bit INTERP    = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [PHASE_W+FRAC_W-1:0]    in_phase,
    output logic                         out_valid,
    output logic signed [AMP_W-1:0]      out_sample
);

    localparam int FULL_W = PHASE_W + FRAC_W;
    localparam int ADDR_W = PHASE_W - 2;
    localparam int MAG_W  = AMP_W - 1;

    logic                   f_valid, f_neg;
    logic [ADDR_W-1:0]      f_addr;
    logic signed [FRAC_W:0] f_delta;

    logic                   r_valid, r_neg;
    logic [MAG_W-1:0]       r_sin, r_cos;
    logic signed [FRAC_W:0] r_delta;

    sine_fold #(
        .PHASE_W (PHASE_W),
        .FRAC_W  (FRAC_W)
    ) u_fold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_phase (in_phase),
        .f_valid  (f_valid),
        .f_neg    (f_neg),
        .f_addr   (f_addr),
        .f_delta  (f_delta)
    );

    sine_quarter_rom #(
        .ADDR_W (ADDR_W),
        .MAG_W  (MAG_W),
        .FRAC_W (FRAC_W),
        .INTERP (INTERP)
    ) u_rom (
        .clk     (clk),
        .rst     (rst),
        .f_valid (f_valid),
        .f_neg   (f_neg),
        .f_addr  (f_addr),
        .f_delta (f_delta),
        .r_valid (r_valid),
        .r_neg   (r_neg),
        .r_sin   (r_sin),
        .r_cos   (r_cos),
        .r_delta (r_delta)
    );

    sine_amp_recon #(
        .ADDR_W    (ADDR_W),
        .MAG_W     (MAG_W),
        .FRAC_W    (FRAC_W),
        .GAIN_FRAC (GAIN_FRAC),
        .INTERP    (INTERP)
    ) u_recon (
        .clk        (clk),
        .rst        (rst),
        .r_valid    (r_valid),
        .r_neg      (r_neg),
        .r_sin      (r_sin),
        .r_cos      (r_cos),
        .r_delta    (r_delta),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    // R1: reset empties the output valid on the next clock
    p_reset_r1: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R2: accepted phase appears three edges after acceptance
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##2 out_valid);

    // R2: an idle input slot stays idle at the output
    p_bubble_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##2 !out_valid);

    // R4: second half-cycle never yields a positive sample
    p_sign_neg_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_phase[FULL_W-1]) |=> ##2 (out_sample <= 0));

    // R4: first half-cycle never yields a negative sample
    p_sign_pos_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_phase[FULL_W-1]) |=> ##2 (out_sample >= 0));

endmodule

// File: tb/sine_lut_conv_tb.sv
module sine_lut_conv_tb;

    localparam int PHASE_W = 12;
    localparam int FRAC_W  = 4;
    localparam int AMP_W   = 16;
    localparam int FULL_W  = PHASE_W + FRAC_W;
    localparam int CODES   = 1 << PHASE_W;
    localparam int AMP     = (1 << (AMP_W - 1)) - 1;
    localparam int LAT     = 3;
    localparam real TWO_PI = 6.283185307179586;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                    rst;
    logic                    in_valid;
    logic [FULL_W-1:0]       in_phase;
    logic                    vld_c, vld_r;
    logic signed [AMP_W-1:0] smp_c, smp_r;

    sine_lut_conv #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W), .AMP_W(AMP_W), .INTERP(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase),
        .out_valid(vld_c), .out_sample(smp_c));

    sine_lut_conv #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W), .AMP_W(AMP_W), .INTERP(1'b0)) u_dut_raw (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase),
        .out_valid(vld_r), .out_sample(smp_r));

    typedef struct {
        bit  vld;
        int  full;
        real ref_c;
        real ref_r;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   raw_seen [CODES];
    bit   raw_have [CODES];

    function automatic real ref_fine(input int full);
        return real'(AMP) * $sin(TWO_PI * real'(full) / real'(1 << FULL_W));
    endfunction

    function automatic real ref_coarse(input int full);
        return real'(AMP) * $sin(TWO_PI * (real'(full >> FRAC_W) + 0.5) / real'(CODES));
    endfunction

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int act, input real exp, input real tol);
        real diff;
        n_checks++;
        diff = real'(act) - exp;
        if (diff < 0.0) diff = -diff;
        if (diff > tol) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %f (tolerance %f)", req, act, exp, tol);
        end
    endtask

    task automatic compare(input exp_t e);
        int p;
        check_int("R2 valid (interp)", int'(vld_c), int'(e.vld));
        check_int("R2 valid (raw)", int'(vld_r), int'(e.vld));
        if (e.vld) begin
            p = e.full >> FRAC_W;
            check_near("R6 interpolated sample", int'(smp_c), e.ref_c, 2.0);
            check_near("R3 table sample", int'(smp_r), e.ref_r, 1.0);
            check_int("R7 lower bound", int'(smp_c >= -AMP), 1);
            if (raw_have[p]) begin
                check_int("R8 residue ignored", int'(smp_r), raw_seen[p]);
            end else begin
                raw_have[p] = 1'b1;
                raw_seen[p] = int'(smp_r);
            end
        end
    endtask

    task automatic step(input bit vld, input int full);
        exp_t e;
        @(negedge clk);
        if (q.size() >= LAT) begin
            e = q.pop_front();
            compare(e);
        end
        in_valid = vld;
        in_phase = FULL_W'(full);
        e.vld   = vld;
        e.full  = full;
        e.ref_c = ref_fine(full);
        e.ref_r = ref_coarse(full);
        q.push_back(e);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2 watchdog: actual run still busy, expected completion");
        finish_run();
    end

    initial begin
        int edge_codes [8] = '{0, 1023, 1024, 2047, 2048, 3071, 3072, 4095};
        int edge_res   [3] = '{0, 8, 15};

        rst      = 1'b1;
        in_valid = 1'b0;
        in_phase = '0;
        repeat (3) @(negedge clk);
        // R1: valid input during reset must not reach the output
        in_valid = 1'b1;
        in_phase = 16'h1234;
        repeat (4) @(negedge clk);
        check_int("R1 reset valid (interp)", int'(vld_c), 0);
        check_int("R1 reset valid (raw)", int'(vld_r), 0);
        rst      = 1'b0;
        in_valid = 1'b0;

        // R1: idle cycles right after reset release
        for (int k = 0; k < 4; k++) step(1'b0, 0);

        // continuous sweep of every coarse code, residue stepping
        for (int p = 0; p < CODES; p++) step(1'b1, (p << FRAC_W) | ((p * 7) % 16));

        // second sweep, random residue and random idle slots
        for (int p = 0; p < CODES; p++) begin
            if (($urandom % 4) == 0) step(1'b0, 0);
            step(1'b1, (p << FRAC_W) | int'($urandom % 16));
        end

        // quarter edges with extreme and centre residues (R5, R6)
        foreach (edge_codes[i]) begin
            foreach (edge_res[j]) step(1'b1, (edge_codes[i] << FRAC_W) | edge_res[j]);
        end

        for (int k = 0; k < LAT + 1; k++) step(1'b0, 0);

        // R4: half-cycle negation of the table-only samples
        for (int p = 0; p < CODES / 2; p++) begin
            check_int("R4 negation", raw_seen[p + CODES / 2], -raw_seen[p]);
        end
        // R5: reflected quarters
        for (int p = 0; p < CODES / 4; p++) begin
            check_int("R5 reflection pos", raw_seen[CODES / 2 - 1 - p], raw_seen[p]);
            check_int("R5 reflection neg", raw_seen[CODES - 1 - p], raw_seen[CODES / 2 + p]);
        end

        finish_run();
    end

endmodule